// File: doc/BRIEF.md
# Five-Source Nested Interrupt Controller

This block sits between a small 4-bit control core and five interrupt sources. Two sources are external pins. The other three are internal single-cycle pulses: serial-transfer completion, timer 0 and timer 1. Each external pin is first brought into the clock domain. Its edge detector can be set to react to rising or to falling transitions. Every event latches a pending flag.

Pending flags are gated by a per-source enable and a global enable. The highest-priority survivor is then offered to the core as a request strobe, together with a 3-bit source code, in the same cycle.

The controller keeps a stack of the priorities currently being serviced, at most four deep. A new request reaches the core only when nothing is active, or when it strictly outranks the handler on top and a free level remains. An acknowledge pulse takes the offered source: it clears that pending flag and pushes a level. A return pulse pops one level. A separate wake output tells halt logic that an enabled event is waiting, whatever the nesting state.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, no source is pending, `irq_req` and `wake` are 0 and `nest_lvl` is 0.
- R2: An external pin set to rising mode (`ext_rise` bit = 1) sets its pending flag on a low-to-high transition. A pin set to falling mode (bit = 0) sets it on a high-to-low transition. The opposite transition is ignored. The request appears after the third rising clock edge that follows the pin change.
- R3: Changing `ext_rise` while a pin holds a steady level never sets that pin's pending flag.
- R4: A one-cycle pulse on `sio_done`, `tmr0_evt` or `tmr1_evt` sets its pending flag. The request is visible right after the clock edge that samples the pulse.
- R5: Source codes are ext pin 0 = 0, ext pin 1 = 1, serial = 2, timer 0 = 3, timer 1 = 4. A lower code has higher priority. `irq_vec` carries the lowest code among enabled pending sources and is meaningful whenever `irq_req` is 1.
- R6: A source whose `src_en` bit (bit index = source code) is 0, or any source while `glob_en` is 0, raises no request. Its pending flag is kept and requests once enabled.
- R7: `irq_ack` while `irq_req` is 1 and `irq_ret` is 0 clears the pending flag of `irq_vec` and raises `nest_lvl` by one after the edge. `irq_ack` while `irq_req` is 0 has no effect.
- R8: With at least one level active, a source requests only if its code is strictly lower than the code on top of the stack. Equal or higher codes wait.
- R9: When `nest_lvl` is 4, `irq_req` stays 0 even for a higher-priority pending source.
- R10: `irq_ret` lowers `nest_lvl` by one. At level 0 it has no effect. When `irq_ret` and `irq_ack` are high together, the acknowledge is ignored.
- R11: `wake` is 1 whenever `glob_en` is 1 and some pending source is enabled, including while nesting blocks `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 2 | Asynchronous external request pins |
| ext_rise | input | 2 | Per-pin edge select: 1 rising, 0 falling |
| sio_done | input | 1 | Serial transfer done pulse |
| tmr0_evt | input | 1 | Timer 0 period pulse |
| tmr1_evt | input | 1 | Timer 1 period pulse |
| src_en | input | 5 | Per-source enable, bit index = source code |
| glob_en | input | 1 | Global enable |
| irq_ack | input | 1 | Core takes the offered request |
| irq_ret | input | 1 | Core returns from a handler |
| irq_req | output | 1 | Request strobe to the core |
| irq_vec | output | 3 | Source code of the offered request |
| nest_lvl | output | 3 | Number of active levels, 0 to 4 |
| wake | output | 1 | Enabled event pending, for halt exit |

## Verification
A lost or stuck pending flag shows at `irq_req`/`irq_vec` as soon as the source becomes the top enabled candidate. With `wake`, it shows in the very next cycle. A corrupted priority stack shows as a wrong preemption decision at the next event whose rank lies between the true and the stored top. It also shows as a `nest_lvl` count off by one right after an acknowledge or return. A bad synchronizer shows as a request one edge early or late after a pin change, or as a spurious request after a polarity flip.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC   = 5;
  localparam int NEXT   = 2;
  localparam int VEC_W  = $clog2(NSRC);
  localparam int NEST_D = 4;
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  // transition-based: the select only chooses direction, never forms an edge itself
  always_comb begin
    if (rise_sel_i) edge_o = sync_q & ~last_q;
    else            edge_o = ~sync_q & last_q;
  end

  assert_edge_needs_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> (sync_q != last_q));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 5,
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cand_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        any_o = 1'b1;
        idx_o = W'(i);
      end
    end
  end

  logic [N-1:0] above_mask;
  assign above_mask = (N'(1) << idx_o) - N'(1);

  assert_pick_highest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (cand_i[idx_o] && ((cand_i & above_mask) == '0)));
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int DEPTH = 4,
  parameter int VW    = 3,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [VW-1:0] push_val_i,
  output logic [VW-1:0] top_o,
  output logic [LW-1:0] lvl_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [VW-1:0] slot_q [DEPTH];
  logic [VW-1:0] slot_d [DEPTH];
  logic [LW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  assign empty_o = (lvl_q == '0);
  assign full_o  = (lvl_q == LW'(DEPTH));
  assign lvl_o   = lvl_q;
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & ~full_o & ~pop_i;

  always_comb begin
    top_o = '1;
    for (int i = 0; i < DEPTH; i++)
      if (LW'(i + 1) == lvl_q) top_o = slot_q[i];
  end

  always_comb begin
    lvl_d = lvl_q;
    for (int i = 0; i < DEPTH; i++) slot_d[i] = slot_q[i];
    if (do_pop) begin
      lvl_d = lvl_q - LW'(1);
    end else if (do_push) begin
      lvl_d = lvl_q + LW'(1);
      for (int i = 0; i < DEPTH; i++)
        if (LW'(i) == lvl_q) slot_d[i] = push_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      lvl_q <= lvl_d;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
    end
  end

  assert_lvl_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(DEPTH));
  assert_no_push_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !push_i);
  assert_push_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |=> (lvl_q == $past(lvl_q) + LW'(1)));
  assert_pop_shrinks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !empty_o) |=> (lvl_q == $past(lvl_q) - LW'(1)));
  assert_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o) |=> (lvl_q == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = NSRC,
  parameter int NUM_EXT = NEXT,
  parameter int MAX_LVL = NEST_D,
  localparam int VW     = $clog2(NUM_SRC),
  localparam int LW     = $clog2(MAX_LVL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_pin,
  input  logic [NUM_EXT-1:0] ext_rise,
  input  logic               sio_done,
  input  logic               tmr0_evt,
  input  logic               tmr1_evt,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               glob_en,
  input  logic               irq_ack,
  input  logic               irq_ret,
  output logic               irq_req,
  output logic [VW-1:0]      irq_vec,
  output logic [LW-1:0]      nest_lvl,
  output logic               wake
);
  logic [NUM_EXT-1:0] ext_edge;
  logic [NUM_SRC-1:0] evt, cand, clr_mask;
  logic [NUM_SRC-1:0] pend_q, pend_d;
  logic               any_c, take, st_full, st_empty, allow;
  logic [VW-1:0]      pick_idx, top_vec;

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
    irq_edge_sync u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (ext_pin[g]),
      .rise_sel_i (ext_rise[g]),
      .edge_o     (ext_edge[g])
    );
  end

  assign evt  = {tmr1_evt, tmr0_evt, sio_done, ext_edge};
  assign cand = pend_q & src_en & {NUM_SRC{glob_en}};

  irq_prio_pick #(.N(NUM_SRC), .W(VW)) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .cand_i (cand),
    .any_o  (any_c),
    .idx_o  (pick_idx)
  );

  irq_nest_stack #(.DEPTH(MAX_LVL), .VW(VW)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (take),
    .pop_i      (irq_ret),
    .push_val_i (pick_idx),
    .top_o      (top_vec),
    .lvl_o      (nest_lvl),
    .full_o     (st_full),
    .empty_o    (st_empty)
  );

  assign allow   = st_empty | (~st_full & (pick_idx < top_vec));
  assign irq_req = any_c & allow;
  assign irq_vec = pick_idx;
  assign wake    = any_c;
  assign take    = irq_ack & irq_req & ~irq_ret;

  always_comb begin
    clr_mask = '0;
    if (take) clr_mask = NUM_SRC'(1) << pick_idx;
    pend_d = (pend_q & ~clr_mask) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assert_req_backed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (glob_en && pend_q[irq_vec] && src_en[irq_vec]));
  assert_no_req_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_lvl == LW'(MAX_LVL)) |-> !irq_req);
  assert_preempt_strict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && nest_lvl != '0) |-> (irq_vec < top_vec));
  assert_wake_covers_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> wake);
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !evt[irq_vec]) |=> !pend_q[$past(irq_vec)]);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 5;
  localparam int MAXL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ext_pin = '0, ext_rise = '0;
  logic sio_done = 0, tmr0_evt = 0, tmr1_evt = 0;
  logic [4:0] src_en = '0;
  logic glob_en = 0, irq_ack = 0, irq_ret = 0;
  logic irq_req, wake;
  logic [2:0] irq_vec, nest_lvl;

  int checks = 0, errors = 0;
  int seed = 32'h5eed;

  // reference model state
  logic [1:0] m_s1 = '0, m_s2 = '0, m_s3 = '0;
  logic [4:0] m_pend = '0;
  int m_stk [MAXL];
  int m_dep = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_rise(ext_rise),
    .sio_done(sio_done), .tmr0_evt(tmr0_evt), .tmr1_evt(tmr1_evt),
    .src_en(src_en), .glob_en(glob_en), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_req(irq_req), .irq_vec(irq_vec), .nest_lvl(nest_lvl), .wake(wake)
  );

  function automatic logic [4:0] m_cand();
    return m_pend & src_en & {5{glob_en}};
  endfunction

  function automatic int m_idx();
    logic [4:0] c = m_cand();
    for (int i = 0; i < NS; i++) if (c[i]) return i;
    return -1;
  endfunction

  function automatic logic m_req();
    int ix = m_idx();
    if (ix < 0) return 1'b0;
    if (m_dep == 0) return 1'b1;
    if (m_dep >= MAXL) return 1'b0;
    return (ix < m_stk[m_dep-1]);
  endfunction

  function automatic logic m_wake();
    return |m_cand();
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic m_update();
    logic take;
    logic [4:0] ev;
    int ix;
    ix = m_idx();
    take = irq_ack & m_req() & ~irq_ret;
    for (int p = 0; p < 2; p++)
      ev[p] = ext_rise[p] ? (m_s2[p] & ~m_s3[p]) : (~m_s2[p] & m_s3[p]);
    ev[2] = sio_done; ev[3] = tmr0_evt; ev[4] = tmr1_evt;
    if (take) m_pend[ix] = 1'b0;
    m_pend = m_pend | ev;
    if (irq_ret) begin
      if (m_dep > 0) m_dep--;
    end else if (take) begin
      m_stk[m_dep] = ix;
      m_dep++;
    end
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
  endtask

  // inputs are already driven; advance one clock and compare every output
  task automatic step(input string tag);
    logic er;
    m_update();
    @(posedge clk);
    @(negedge clk);
    er = m_req();
    chk(irq_req === er, {tag, " req"}, int'(irq_req), int'(er));
    if (er) chk(int'(irq_vec) == m_idx(), {tag, " vec"}, int'(irq_vec), m_idx());
    chk(int'(nest_lvl) == m_dep, {tag, " lvl"}, int'(nest_lvl), m_dep);
    chk(wake === m_wake(), {tag, " wake"}, int'(wake), int'(m_wake()));
    sio_done = 0; tmr0_evt = 0; tmr1_evt = 0; irq_ack = 0; irq_ret = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic ack_one(input string tag);
    irq_ack = 1; step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < MAXL; i++) m_stk[i] = 0;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(irq_req === 1'b0, "R1 req", int'(irq_req), 0);
    chk(wake === 1'b0, "R1 wake", int'(wake), 0);
    chk(nest_lvl === 3'd0, "R1 lvl", int'(nest_lvl), 0);
    rst_n = 1;
    src_en = 5'h1f; glob_en = 1; ext_rise = 2'b11;
    idle(4, "R1");

    // R2 rising edge latency on pin 0
    ext_pin[0] = 1;
    step("R2"); step("R2");
    chk(irq_req === 1'b0, "R2 early", int'(irq_req), 0);
    step("R2");
    chk(irq_req === 1'b1 && irq_vec == 3'd0, "R2 rise", int'(irq_vec), 0);
    ack_one("R7");
    chk(nest_lvl == 3'd1, "R7 push", int'(nest_lvl), 1);
    irq_ret = 1; step("R10");
    ext_pin[0] = 0; idle(4, "R2");
    chk(wake === 1'b0, "R2 fall ignored", int'(wake), 0);

    // R3 polarity flips on steady pins
    ext_rise[0] = 0; idle(4, "R3");
    ext_pin[1] = 1; idle(4, "R2");
    ack_one("R7");
    irq_ret = 1; step("R10");
    ext_rise[1] = 0; idle(4, "R3");
    chk(wake === 1'b0, "R3 no false edge", int'(wake), 0);

    // R4 and R6: masking keeps pending
    glob_en = 0; sio_done = 1; step("R4");
    chk(irq_req === 1'b0 && wake === 1'b0, "R6 glob off", int'(irq_req), 0);
    src_en = 5'h1b; glob_en = 1; step("R6");
    chk(irq_req === 1'b0, "R6 src off", int'(irq_req), 0);
    src_en = 5'h1f; step("R6");
    chk(irq_req === 1'b1 && irq_vec == 3'd2, "R6 kept", int'(irq_vec), 2);
    ack_one("R7");
    irq_ret = 1; step("R10");

    // R8 preemption only by strictly higher priority
    tmr0_evt = 1; step("R4");
    chk(irq_req === 1'b1 && irq_vec == 3'd3, "R4 tmr0", int'(irq_vec), 3);
    ack_one("R8");
    tmr1_evt = 1; step("R8");
    chk(irq_req === 1'b0 && wake === 1'b1, "R8 lower waits/R11", int'(irq_req), 0);
    tmr0_evt = 1; step("R8");
    chk(irq_req === 1'b0, "R8 equal waits", int'(irq_req), 0);
    sio_done = 1; step("R8");
    chk(irq_req === 1'b1 && irq_vec == 3'd2, "R8 preempt", int'(irq_vec), 2);
    ack_one("R8");
    irq_ret = 1; step("R10"); irq_ret = 1; step("R10");
    ack_one("R5"); ack_one("R5");
    irq_ret = 1; step("R10"); irq_ret = 1; step("R10");

    // R9 four levels then a top-priority source is held off
    tmr1_evt = 1; step("R9"); ack_one("R9");
    tmr0_evt = 1; step("R9"); ack_one("R9");
    sio_done = 1; step("R9"); ack_one("R9");
    ext_pin[1] = 0; idle(3, "R9"); ack_one("R9");
    chk(nest_lvl == 3'd4, "R9 full", int'(nest_lvl), 4);
    ext_rise[0] = 1; ext_pin[0] = 1; idle(3, "R9");
    chk(irq_req === 1'b0 && wake === 1'b1, "R9 capped", int'(irq_req), 0);
    irq_ret = 1; irq_ack = 1; step("R10");
    chk(nest_lvl == 3'd3 && irq_req === 1'b1 && irq_vec == 3'd0, "R10 ret wins", int'(nest_lvl), 3);
    for (int i = 0; i < 4; i++) begin irq_ret = 1; step("R10"); end
    chk(nest_lvl == 3'd0, "R10 floor", int'(nest_lvl), 0);
    ack_one("R7"); irq_ret = 1; step("R10");

    // constrained random against the model
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(15) == 0) ext_pin[$urandom_range(1)] ^= 1'b1;
      if ($urandom_range(63) == 0) ext_rise = 2'($urandom_range(3));
      if ($urandom_range(31) == 0) src_en = 5'($urandom_range(31));
      if ($urandom_range(31) == 0) glob_en = ($urandom_range(7) != 0);
      sio_done = ($urandom_range(11) == 0);
      tmr0_evt = ($urandom_range(11) == 0);
      tmr1_evt = ($urandom_range(11) == 0);
      irq_ack  = ($urandom_range(2) == 0);
      irq_ret  = ($urandom_range(5) == 0);
      step("R5 R7 R8 R11 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule